// File: doc/BRIEF.md
# Sequential Line Prefetch Queue

This block sits beside a direct-mapped first-level cache and hides the latency of sequential misses. When the cache misses on a line, it presents the line address on the lookup port. If that address is the line waiting at the front of the queue and the line's data has arrived, the block hands the line over in the same cycle. The queue then advances and requests one more line from the next memory level. Any other lookup is answered as a miss. The queue is emptied and refilled with the lines that follow the missed address, in ascending order.

Each slot keeps a line tag, a ready flag and a data word. Only the front slot is ever compared with a lookup address. A lookup that matches the front tag before its data has come back is held open until the data arrives. Returned lines carry their address. A return is written only into a waiting slot whose tag matches, so replies to requests issued before a restart are dropped.

The control is a three-state machine:
- `SB_EMPTY`: no stream is running.
- `SB_FILL`: a stream is running.
- `SB_HOLD`: the front tag matched but its data is still missing.

The transitions are:
- first lookup: `SB_EMPTY`→`SB_FILL`, with a restart.
- front hit: `SB_FILL`→`SB_FILL`, with an advance.
- front mismatch: `SB_FILL`→`SB_FILL`, with a restart.
- pending front: `SB_FILL`→`SB_HOLD`.
- data arrival: `SB_HOLD`→`SB_FILL`, with an advance.

Top module: `seq_stream_prefetch`

## Requirements
- R1: After reset no memory request is raised and no lookup is answered until a lookup arrives.
- R2: A lookup made while no stream runs, or whose address differs from the front tag, is answered in the same cycle with `lk_done`=1 and `lk_hit`=0. Requests then start at the lookup address plus one and rise by one line each.
- R3: No more than DEPTH lines are requested ahead of the cache; `req_valid` is low while all DEPTH slots are taken.
- R4: A lookup whose address sits in a slot other than the front is a miss and restarts the stream from that address.
- R5: A lookup that matches the front tag with its data present is answered in the same cycle with `lk_done`=1, `lk_hit`=1 and `lk_data` equal to the line returned for that address.
- R6: Each front hit frees one slot, and exactly one new request follows for the line after the last one requested.
- R7: A lookup that matches the front tag before the data is back gets no answer until that data arrives, and is then answered as a hit.
- R8: A returned line whose address matches no waiting slot leaves every slot unchanged, so lines requested before a restart never reach the cache.
- R9: While `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged until the request is taken or a restart occurs.
- R10: A run of sequential lookups longer than DEPTH lines is served entirely from the queue, in order, as slots are reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Cache presents a missed line address; held until `lk_done` |
| lk_addr | input | ADDR_W | Missed line address |
| lk_done | output | 1 | Lookup answered this cycle |
| lk_hit | output | 1 | 1 = line supplied, 0 = miss (stream restarted) |
| lk_data | output | DATA_W | Line handed to the cache on a hit |
| req_valid | output | 1 | Prefetch request to memory |
| req_addr | output | ADDR_W | Line address requested |
| req_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | A requested line returns |
| rsp_addr | input | ADDR_W | Address of the returned line |
| rsp_data | input | DATA_W | Returned line data |

## Verification
The queue is driven with several lookup patterns, each checked against a model that tracks the expected front address:
- A cold miss, then a long ascending run that wraps the slots. This separates correct ordering and refill from pointer slips.
- A jump to a line that is queued but not at the front. This tells a front-only comparator apart from a search of all slots.
- A lookup issued right after a restart under long memory latency. This shows a held answer, not an early miss or stale data.
- Two restarts in close succession with replies still in flight. This exposes any return path that ignores the tag.
- Memory back-pressure. This checks that requests stay stable and that the request count stays capped.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY = 2'd0,
        SB_FILL  = 2'd1,
        SB_HOLD  = 2'd2
    } sb_state_e;

endpackage

// File: rtl/sb_slot.sv
module sb_slot #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_tag,
    input  logic              take,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              used,
    output logic              ready,
    output logic [ADDR_W-1:0] tag,
    output logic [DATA_W-1:0] data
);

    logic fill_match;
    assign fill_match = rsp_valid && used && !ready && (tag == rsp_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used  <= 1'b0;
            ready <= 1'b0;
            tag   <= '0;
            data  <= '0;
        end else if (clear) begin
            used  <= 1'b0;
            ready <= 1'b0;
        end else if (load) begin
            used  <= 1'b1;
            ready <= 1'b0;
            tag   <= load_tag;
        end else if (take) begin
            used  <= 1'b0;
            ready <= 1'b0;
        end else if (fill_match) begin
            ready <= 1'b1;
            data  <= rsp_data;
        end
    end

endmodule

// File: rtl/sb_slot_ring.sv
module sb_slot_ring #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_tag,
    input  logic              pop,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              head_used,
    output logic              head_ready,
    output logic [ADDR_W-1:0] head_tag,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  occ
);

    localparam int SUM_W = CNT_W + 1;

    logic [PTR_W-1:0] hd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] tail_sum;
    logic [PTR_W-1:0] tail_idx;

    logic              s_used  [DEPTH];
    logic              s_ready [DEPTH];
    logic [ADDR_W-1:0] s_tag   [DEPTH];
    logic [DATA_W-1:0] s_data  [DEPTH];

    assign tail_sum = SUM_W'(hd_q) + SUM_W'(cnt_q);
    assign tail_idx = (tail_sum >= SUM_W'(DEPTH)) ? PTR_W'(tail_sum - SUM_W'(DEPTH))
                                                  : PTR_W'(tail_sum);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sb_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (flush),
            .load     (alloc && (tail_idx == PTR_W'(g))),
            .load_tag (alloc_tag),
            .take     (pop && (hd_q == PTR_W'(g))),
            .rsp_valid(rsp_valid),
            .rsp_addr (rsp_addr),
            .rsp_data (rsp_data),
            .used     (s_used[g]),
            .ready    (s_ready[g]),
            .tag      (s_tag[g]),
            .data     (s_data[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (pop) begin
                hd_q <= (hd_q == PTR_W'(DEPTH - 1)) ? '0 : hd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    assign head_used  = s_used[hd_q];
    assign head_ready = s_ready[hd_q];
    assign head_tag   = s_tag[hd_q];
    assign head_data  = s_data[hd_q];
    assign occ        = cnt_q;

endmodule

// File: rtl/sb_req_gen.sv
module sb_req_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic              enable,
    input  logic              room,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              fire
);

    logic [ADDR_W-1:0] next_q;

    assign req_valid = enable && room;
    assign req_addr  = next_q;
    assign fire      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (restart) begin
            next_q <= restart_addr + 1'b1;
        end else if (fire) begin
            next_q <= next_q + 1'b1;
        end
    end

endmodule

// File: rtl/seq_stream_prefetch.sv
module seq_stream_prefetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data
);
    import sb_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_state_e         state_q, state_d;
    logic              flush, pop, fire, room, enable;
    logic              head_used, head_ready, head_match;
    logic [ADDR_W-1:0] head_tag;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  occ_cnt;

    assign head_match = head_used && (head_tag == lk_addr);
    assign room       = occ_cnt < CNT_W'(DEPTH);
    assign enable     = (state_q != SB_EMPTY) && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: if (lk_valid) state_d = SB_FILL;
            SB_FILL:  if (lk_valid && head_match && !head_ready) state_d = SB_HOLD;
            SB_HOLD:  if (lk_valid && head_ready) state_d = SB_FILL;
            default:  state_d = SB_EMPTY;
        endcase
    end

    always_comb begin
        lk_done = 1'b0;
        lk_hit  = 1'b0;
        flush   = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            SB_EMPTY: begin
                if (lk_valid) begin
                    lk_done = 1'b1;
                    flush   = 1'b1;
                end
            end
            SB_FILL: begin
                if (lk_valid && head_match && head_ready) begin
                    lk_done = 1'b1;
                    lk_hit  = 1'b1;
                    pop     = 1'b1;
                end else if (lk_valid && !head_match) begin
                    lk_done = 1'b1;
                    flush   = 1'b1;
                end
            end
            SB_HOLD: begin
                if (lk_valid && head_ready) begin
                    lk_done = 1'b1;
                    lk_hit  = 1'b1;
                    pop     = 1'b1;
                end
            end
            default: begin
                lk_done = 1'b0;
            end
        endcase
    end

    assign lk_data = head_data;

    sb_req_gen #(.ADDR_W(ADDR_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (flush),
        .restart_addr(lk_addr),
        .enable      (enable),
        .room        (room),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .fire        (fire)
    );

    sb_slot_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc     (fire),
        .alloc_tag (req_addr),
        .pop       (pop),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data),
        .head_used (head_used),
        .head_ready(head_ready),
        .head_tag  (head_tag),
        .head_data (head_data),
        .occ       (occ_cnt)
    );

endmodule

// File: rtl/seq_stream_prefetch_chk.sv
module seq_stream_prefetch_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_done,
    input logic              lk_hit,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  occ_cnt
);

    AST_DONE_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> lk_valid); // R2

    AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |=> (!req_valid || req_addr == ADDR_W'($past(lk_addr) + 1'b1))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH)); // R3

    AST_REQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || req_addr == ADDR_W'($past(req_addr) + 1'b1))); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> ((lk_done && !lk_hit) || (req_valid && $stable(req_addr)))); // R9

endmodule

bind seq_stream_prefetch seq_stream_prefetch_chk #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .occ_cnt  (occ_cnt)
);

// File: tb/seq_stream_prefetch_test.sv
module seq_stream_prefetch_test;

    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_done, lk_hit;
    logic [DW-1:0] lk_data;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_ready = 1'b1;
    logic          rsp_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [DW-1:0] rsp_data = '0;

    always #10 clk = ~clk;

    seq_stream_prefetch #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_data(lk_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 3;
    bit done_run = 0;

    typedef struct { logic [AW-1:0] addr; int due; } mreq_t;
    typedef struct { logic hit; logic [DW-1:0] data; logic [AW-1:0] addr; } exp_t;
    mreq_t         mq[$];
    logic [AW-1:0] reqlog[$];
    exp_t          sb[$];

    bit            stream_on = 0;
    logic [AW-1:0] exp_head = '0;

    function automatic logic [DW-1:0] line_of(logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) cyc++;

    // memory model: record accepted requests, return lines in order after lat cycles
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            mq.push_back('{addr: req_addr, due: cyc + lat});
            reqlog.push_back(req_addr);
        end
    end

    always @(posedge clk) begin
        #2;
        if (mq.size() > 0 && mq[0].due <= cyc) begin
            rsp_valid = 1'b1;
            rsp_addr  = mq[0].addr;
            rsp_data  = line_of(mq[0].addr);
            void'(mq.pop_front());
        end else begin
            rsp_valid = 1'b0;
        end
    end

    // monitor: compare every answered lookup with the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && lk_valid && lk_done) begin
            if (sb.size() == 0) begin
                chk(0, "R2 unexpected answer", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(lk_hit == e.hit, e.hit ? "R5 hit flag" : "R2 miss flag", lk_hit, e.hit);
                if (e.hit) chk(lk_data == e.data, "R5 line data", lk_data, e.data);
            end
        end
    end

    task automatic lookup(input logic [AW-1:0] a, output int waited);
        exp_t e;
        e.addr = a;
        e.hit  = stream_on && (a == exp_head);
        e.data = line_of(a);
        sb.push_back(e);
        if (e.hit) exp_head = exp_head + 1'b1;
        else begin
            stream_on = 1;
            exp_head  = a + 1'b1;
        end
        @(posedge clk); #2;
        lk_valid = 1'b1;
        lk_addr  = a;
        waited   = 0;
        forever begin
            @(negedge clk);
            if (lk_done) break;
            waited++;
        end
        @(posedge clk); #2;
        lk_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);
        chk(lk_done == 1'b0, "R1 no answer after reset", lk_done, 0);

        // cold miss, fill to depth
        lookup(16'd100, w);
        idle(10);
        @(negedge clk);
        chk(reqlog.size() == DEPTH, "R3 requests capped at depth", reqlog.size(), DEPTH);
        for (int i = 0; i < DEPTH && i < reqlog.size(); i++)
            chk(reqlog[i] == 16'(101 + i), "R2 ascending request order", reqlog[i], 101 + i);
        chk(req_valid == 1'b0, "R3 request low while full", req_valid, 0);

        // one hit -> one new request
        reqlog.delete();
        lookup(16'd101, w);
        idle(6);
        chk(reqlog.size() == 1, "R6 one refill per hit", reqlog.size(), 1);
        if (reqlog.size() > 0) chk(reqlog[0] == 16'd105, "R6 refill address", reqlog[0], 105);

        // long sequential run wraps the slots
        for (int a = 102; a <= 110; a++) lookup(16'(a), w);   // R10
        idle(10);

        // queued but not at front -> miss and restart
        reqlog.delete();
        lookup(16'd113, w);
        idle(10);
        chk(reqlog.size() == DEPTH, "R4 restart refills", reqlog.size(), DEPTH);
        if (reqlog.size() > 0) chk(reqlog[0] == 16'd114, "R4 restart address", reqlog[0], 114);

        // front tag pending -> held answer
        lat = 14;
        lookup(16'd300, w);
        lookup(16'd301, w);
        chk(w >= 8, "R7 answer held for data", w, 8);

        // stale replies after quick restarts
        lookup(16'd400, w);
        idle(4);
        lookup(16'd500, w);
        idle(40);
        lookup(16'd501, w);                                    // R8 data checked by monitor
        lookup(16'd502, w);

        // back-pressure
        lat = 3;
        idle(20);
        @(posedge clk); #2 req_ready = 1'b0;
        lookup(16'd600, w);
        idle(2);
        @(negedge clk);
        chk(req_valid && req_addr == 16'd601, "R9 request raised", {req_valid, req_addr}, {1'b1, 16'd601});
        idle(5);
        @(negedge clk);
        chk(req_valid && req_addr == 16'd601, "R9 request held", {req_valid, req_addr}, {1'b1, 16'd601});
        @(posedge clk); #2 req_ready = 1'b1;
        idle(10);
        lookup(16'd601, w);
        idle(5);
        chk(sb.size() == 0, "R5 all lookups answered", sb.size(), 0);
        finish_run();
    end

endmodule